// File: doc/BRIEF.md
# Coalescing Store Buffer

This block is a small first-in first-out store buffer placed between a core's store port and a memory port that works on whole 32-bit words. Each slot holds a word address, four byte lanes of data and a four-bit lane-valid mask. A byte, halfword or word store to the same word as the youngest pending slot is folded into that slot instead of taking a new one. As a result, a run of narrow stores to one word usually leaves the buffer as a single write that covers all four lanes. The memory side can then write the word directly and skip reading the old contents.

Slots leave in program order through a valid/ready commit port that carries the word address, data and mask. A flag on that port marks each commit as either a full-word write or a partial write. A partial write forces the downstream side to read, merge and write back. A flush input stops new stores and drains every slot, and an empty output shows when nothing is pending.

Store lanes use a fixed encoding: enable bit i selects byte lane i, which is data bits [8i+7:8i].

Top module: `store_coalesce_buf`

## Requirements
- R1: While reset is asserted and after it is released with no traffic, `empty` is 1, `cm_valid` is 0 and `st_ready` is 1.
- R2: An accepted store whose word address equals the youngest pending slot is merged into that slot. Enabled lanes take the new bytes, the other lanes keep their old bytes, and the slot mask becomes the OR of both masks.
- R3: An accepted store that does not match the youngest slot takes a new slot, even if it matches an older slot. Lanes that are not enabled in a fresh slot read as zero.
- R4: Commits are offered oldest first. `cm_addr`, `cm_data` and `cm_mask` show the oldest slot.
- R5: `cm_full` is 1 when the offered mask is 4'b1111 and 0 for any other mask.
- R6: With two or more slots pending, an offered commit that is not accepted stays offered with unchanged address, data and mask. A partial commit keeps its slot until it is accepted.
- R7: When all DEPTH slots are used, `st_ready` is 0 for a store that does not match the youngest slot. A store that matches the youngest slot is still accepted.
- R8: With exactly one slot pending, `cm_valid` is 0 in any cycle where a store merging into that slot is accepted.
- R9: A flush drops `st_ready` in its own cycle and keeps it low until every slot has committed.
- R10: `empty` is 1 exactly when no slot is pending. When `empty` is 1, no commit is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when valid |
| st_addr | input | ADDR_W | Word address of the store |
| st_data | input | 32 | Lane-aligned store data |
| st_be | input | 4 | Lane enables, bit i for byte lane i |
| flush | input | 1 | Drain all slots and block stores until empty |
| cm_valid | output | 1 | Commit offered |
| cm_ready | input | 1 | Commit accepted by memory side |
| cm_addr | output | ADDR_W | Word address of the oldest slot |
| cm_data | output | 32 | Data of the oldest slot |
| cm_mask | output | 4 | Valid lanes of the oldest slot |
| cm_full | output | 1 | 1 for a full-word commit, 0 for a partial one |
| empty | output | 1 | No slot pending |

## Verification
A wrong merge shows on `cm_data` or `cm_mask` when the affected slot reaches the head, which can be up to DEPTH commits later. For that reason the bench compares every offered commit against a queue model, not only the final memory image. A slip in the pointers or the occupancy count shows on `st_ready` or `empty` in the same cycle it happens, because both are compared on every clock. A head that commits during a merge shows as an extra partial commit, and the model flags the `cm_valid` mismatch in that cycle.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
    localparam int unsigned SB_LANES  = 4;
    localparam int unsigned SB_LANE_W = 8;
    localparam int unsigned SB_WORD_W = SB_LANES * SB_LANE_W;

    function automatic logic all_lanes(input logic [SB_LANES-1:0] m);
        return &m;
    endfunction
endpackage

// File: rtl/sb_lane_merge.sv
`timescale 1ns/1ps
module sb_lane_merge #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned W     = LANES * LANE_W
) (
    input  logic [W-1:0]     old_data,
    input  logic [LANES-1:0] old_mask,
    input  logic [W-1:0]     new_data,
    input  logic [LANES-1:0] new_mask,
    output logic [W-1:0]     out_data,
    output logic [LANES-1:0] out_mask
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign out_data[g*LANE_W +: LANE_W] =
            new_mask[g] ? new_data[g*LANE_W +: LANE_W] :
            old_mask[g] ? old_data[g*LANE_W +: LANE_W] : '0;
        assign out_mask[g] = old_mask[g] | new_mask[g];
    end
endmodule

// File: rtl/sb_admit.sv
`timescale 1ns/1ps
module sb_admit (
    input  logic st_valid,
    input  logic blocked,
    input  logic tail_match,
    input  logic full,
    input  logic single,
    output logic st_ready,
    output logic do_merge,
    output logic do_push,
    output logic hold_head
);
    logic accept;
    always_comb begin
        st_ready  = !blocked && (tail_match || !full);
        accept    = st_valid && st_ready;
        do_merge  = accept && tail_match;
        do_push   = accept && !tail_match;
        hold_head = do_merge && single;
    end
endmodule

// File: rtl/store_coalesce_buf.sv
`timescale 1ns/1ps
module store_coalesce_buf #(
    parameter int unsigned ADDR_W = 30,
    parameter int unsigned DEPTH  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          st_valid,
    output logic                          st_ready,
    input  logic [ADDR_W-1:0]             st_addr,
    input  logic [sb_pkg::SB_WORD_W-1:0]  st_data,
    input  logic [sb_pkg::SB_LANES-1:0]   st_be,
    input  logic                          flush,
    output logic                          cm_valid,
    input  logic                          cm_ready,
    output logic [ADDR_W-1:0]             cm_addr,
    output logic [sb_pkg::SB_WORD_W-1:0]  cm_data,
    output logic [sb_pkg::SB_LANES-1:0]   cm_mask,
    output logic                          cm_full,
    output logic                          empty
);
    import sb_pkg::*;

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [ADDR_W-1:0]    addr;
        logic [SB_WORD_W-1:0] data;
        logic [SB_LANES-1:0]  mask;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic [PTR_W-1:0]  head;
        logic [PTR_W-1:0]  tail;
        logic [CNT_W-1:0]  count;
        logic              drain;
    } state_t;

    state_t s_q, s_d;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    slot_t                young_q, old_q;
    logic                 nonempty, full, single, tail_match, blocked;
    logic                 do_merge, do_push, hold_head, pop;
    logic [SB_WORD_W-1:0] mg_data, fr_data;
    logic [SB_LANES-1:0]  mg_mask, fr_mask;

    always_comb begin
        young_q    = s_q.slot[s_q.tail];
        old_q      = s_q.slot[s_q.head];
        nonempty   = (s_q.count != '0);
        full       = (s_q.count == CNT_W'(DEPTH));
        single     = (s_q.count == CNT_W'(1));
        tail_match = nonempty && (young_q.addr == st_addr);
        blocked    = flush || s_q.drain;
    end

    sb_lane_merge #(.LANES(SB_LANES), .LANE_W(SB_LANE_W)) u_merge (
        .old_data (young_q.data),
        .old_mask (young_q.mask),
        .new_data (st_data),
        .new_mask (st_be),
        .out_data (mg_data),
        .out_mask (mg_mask)
    );

    sb_lane_merge #(.LANES(SB_LANES), .LANE_W(SB_LANE_W)) u_fresh (
        .old_data ('0),
        .old_mask ('0),
        .new_data (st_data),
        .new_mask (st_be),
        .out_data (fr_data),
        .out_mask (fr_mask)
    );

    sb_admit u_admit (
        .st_valid   (st_valid),
        .blocked    (blocked),
        .tail_match (tail_match),
        .full       (full),
        .single     (single),
        .st_ready   (st_ready),
        .do_merge   (do_merge),
        .do_push    (do_push),
        .hold_head  (hold_head)
    );

    always_comb begin
        cm_valid = nonempty && !hold_head;
        cm_addr  = old_q.addr;
        cm_data  = old_q.data;
        cm_mask  = old_q.mask;
        cm_full  = all_lanes(old_q.mask);
        empty    = !nonempty;
        pop      = cm_valid && cm_ready;
    end

    always_comb begin
        logic [PTR_W-1:0] wr_idx;
        s_d    = s_q;
        wr_idx = nxt(s_q.tail);
        if (pop) begin
            s_d.head = nxt(s_q.head);
        end
        if (do_merge) begin
            s_d.slot[s_q.tail].data = mg_data;
            s_d.slot[s_q.tail].mask = mg_mask;
        end
        if (do_push) begin
            s_d.slot[wr_idx].addr = st_addr;
            s_d.slot[wr_idx].data = fr_data;
            s_d.slot[wr_idx].mask = fr_mask;
            s_d.tail              = wr_idx;
        end
        s_d.count = s_q.count + CNT_W'(do_push) - CNT_W'(pop);
        s_d.drain = (s_q.drain || flush) && (s_d.count != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.tail  <= PTR_W'(DEPTH - 1);
        end else begin
            s_q <= s_d;
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CNT_W'(DEPTH));

    assert_empty_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !cm_valid);

    assert_last_commit_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (single && cm_valid && cm_ready && !(st_valid && st_ready)) |=> empty);

    assert_flush_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty || !st_ready));

    assert_head_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && !cm_ready && s_q.count > CNT_W'(1)) |=>
        (cm_valid && $stable(cm_addr) && $stable(cm_data) && $stable(cm_mask)));

    assert_no_commit_on_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && single && st_addr == cm_addr) |-> !cm_valid);
endmodule

// File: tb/store_coalesce_buf_bench.sv
`timescale 1ns/1ps
module store_coalesce_buf_bench;
    localparam int AW    = 30;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          st_valid, st_ready, flush, cm_valid, cm_ready, cm_full, empty;
    logic [AW-1:0] st_addr, cm_addr;
    logic [31:0]   st_data, cm_data;
    logic [3:0]    st_be, cm_mask;

    always #2.5 clk = ~clk;

    store_coalesce_buf #(.ADDR_W(AW), .DEPTH(DEPTH)) u_store_coalesce_buf (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .flush(flush),
        .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_addr(cm_addr),
        .cm_data(cm_data), .cm_mask(cm_mask), .cm_full(cm_full), .empty(empty)
    );

    int n_chk = 0, n_bad = 0, commits = 0, fulls = 0;
    bit mon_on = 0, done = 0;
    logic [AW-1:0] qa[$];
    logic [31:0]   qd[$];
    logic [3:0]    qm[$];
    bit drain = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] lanes(input logic [3:0] m);
        return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
    endfunction

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Reference model: compared just before every rising edge, then advanced.
    always begin
        @(negedge clk);
        #2;
        if (mon_on) begin
            bit mt, rdy, acc, hold, cv, pop;
            mt   = (qa.size() > 0) && (qa[$] == st_addr);
            rdy  = !(flush || drain) && (mt || qa.size() < DEPTH);
            acc  = st_valid && rdy;
            hold = acc && mt && (qa.size() == 1);
            cv   = (qa.size() > 0) && !hold;
            chk("R10 empty", 64'(empty), 64'(qa.size() == 0));
            chk("R7/R9 st_ready", 64'(st_ready), 64'(rdy));
            chk("R8 cm_valid", 64'(cm_valid), 64'(cv));
            if (cv) begin
                chk("R4/R6 cm_addr", 64'(cm_addr), 64'(qa[0]));
                chk("R2/R3 cm_data", 64'(cm_data), 64'(qd[0]));
                chk("R2 cm_mask", 64'(cm_mask), 64'(qm[0]));
                chk("R5 cm_full", 64'(cm_full), 64'(qm[0] == 4'hF));
            end
            pop = cv && cm_ready;
            if (pop) begin
                commits++;
                if (qm[0] == 4'hF) fulls++;
                void'(qa.pop_front()); void'(qd.pop_front()); void'(qm.pop_front());
            end
            if (acc) begin
                if (mt) begin
                    qd[$] = (qd[$] & ~lanes(st_be)) | (st_data & lanes(st_be));
                    qm[$] = qm[$] | st_be;
                end else begin
                    qa.push_back(st_addr);
                    qd.push_back(st_data & lanes(st_be));
                    qm.push_back(st_be);
                end
            end
            drain = (drain || flush) && (qa.size() != 0);
        end
    end

    task automatic cyc(input bit v, input int a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        st_valid = v;
        st_addr  = AW'(a);
        st_be    = be;
        st_data  = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 4'h0, 32'h0);
    endtask

    initial begin
        rst_n = 0; st_valid = 0; st_addr = '0; st_be = '0; st_data = '0;
        flush = 0; cm_ready = 0;
        repeat (3) @(negedge clk);
        #2;
        chk("R1 reset empty", 64'(empty), 64'd1);
        chk("R1 reset cm_valid", 64'(cm_valid), 64'd0);
        chk("R1 reset st_ready", 64'(st_ready), 64'd1);
        @(negedge clk);
        rst_n  = 1;
        mon_on = 1;

        // Byte stream into one word coalesces into one full commit.
        cyc(1, 5, 4'b0001, 32'h000000A1);
        cyc(1, 5, 4'b0010, 32'h0000B200);
        cyc(1, 5, 4'b0100, 32'h00C30000);
        cyc(1, 5, 4'b1000, 32'hD4000000);
        idle(1);
        commits = 0; fulls = 0;
        @(negedge clk); cm_ready = 1;
        idle(3);
        chk("R2/R5 one full commit", 64'(commits), 64'd1);
        chk("R2/R5 full tagged", 64'(fulls), 64'd1);

        // Fill to capacity, then probe non-matching, youngest and older matches.
        @(negedge clk); cm_ready = 0;
        cyc(1, 1, 4'b0011, 32'h11111111);
        cyc(1, 2, 4'b0011, 32'h22222222);
        cyc(1, 3, 4'b0011, 32'h33333333);
        cyc(1, 4, 4'b0011, 32'h44444444);
        cyc(1, 9, 4'b1111, 32'h99999999);
        cyc(1, 4, 4'b0100, 32'h00550000);
        cyc(1, 2, 4'b1000, 32'h66000000);
        @(negedge clk); cm_ready = 1;
        cyc(1, 2, 4'b1000, 32'h77000000);
        idle(8);
        chk("R3 drained after older-match push", 64'(empty), 64'd1);

        // Flush with stores pending and more stores arriving.
        @(negedge clk); cm_ready = 0;
        cyc(1, 7, 4'b0001, 32'h1);
        cyc(1, 8, 4'b0110, 32'h0ABC00);
        cyc(1, 9, 4'b1111, 32'hCAFEF00D);
        @(negedge clk); flush = 1; st_valid = 1; st_addr = AW'(9);
        @(negedge clk); flush = 0;
        cyc(1, 10, 4'b0001, 32'h5);
        @(negedge clk); cm_ready = 1;
        cyc(1, 11, 4'b0001, 32'h6);
        cyc(1, 11, 4'b0001, 32'h7);
        idle(6);
        chk("R9 flush drained", 64'(empty), 64'd1);

        // Mixed traffic over a few words.
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            st_valid = ($urandom_range(0, 9) < 7);
            st_addr  = AW'($urandom_range(0, 3));
            st_be    = 4'($urandom_range(1, 15));
            st_data  = $urandom;
            cm_ready = ($urandom_range(0, 9) < 6);
            flush    = ($urandom_range(0, 49) == 0);
        end
        @(negedge clk); st_valid = 0; flush = 0; cm_ready = 1;
        idle(10);
        chk("R10 final empty", 64'(empty), 64'd1);
        done = 1;
        report();
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            report();
            $finish;
        end
    end
endmodule